// File: doc/BRIEF.md
# Write Gate Path Sequencer

This block owns the serial write data path of a recording channel for as long as the write gate is high. When the gate rises, the block starts a frame one clock later. In the two framed modes the frame is a run of alternating-bit preamble bytes followed by a sync byte. After that, the normal mode streams encoded user bits taken from the encoder. The test mode streams a PRBS7 sequence instead. A third mode skips all framing and passes the raw input bit straight to the output. The block emits one bit per clock toward the write precompensator, together with a valid strobe and a request strobe to the encoder.

The block also protects the read side. The read front end is squelched and the gain loop is frozen while the gate is high. After the gate drops, the squelch is held on for a programmed number of reference-clock periods, in steps of eight. A one-cycle reference tick input counts those periods.

Mode, preamble length and sync byte are captured when the gate rises, so a change on those inputs during a write has no effect on that write.

Top module: `wg_path_seq`

## Requirements
- R1: While rst_n is low and after its release with wg_i low, wr_valid_o, wr_bit_o, data_req_o, squelch_o and agc_hold_o are all 0.
- R2: In the clock cycle after the first rising edge of clk at which wg_i is seen high, wr_valid_o is 1. In the framed modes (mode_i[1] = 0) the first 8·P output bits are the preamble, where P is pre_len_i. Preamble bit k equals k mod 2, which is 0x55 sent MSB first. P = 0 leaves out the preamble.
- R3: In the framed modes the 8 bits after the preamble are sync_byte_i, sent MSB first.
- R4: Normal mode (mode_i = 2'b00): after the sync byte, wr_bit_o equals enc_bit_i in every cycle and data_req_o is 1. data_req_o is 0 in every other phase.
- R5: Test mode (mode_i = 2'b01): after the sync byte, the output is PRBS7 with polynomial x^7+x^6+1. The register s[6:0] is set to all ones at the rise of the gate. Each payload bit is s[6], and the next state is {s[5:0], s[6]^s[5]}.
- R6: Direct mode (mode_i = 2'b10 or 2'b11): from the first output cycle, wr_bit_o equals raw_bit_i. There is no preamble or sync byte, and data_req_o stays 0.
- R7: mode_i, pre_len_i and sync_byte_i are captured when the gate rises. Changing them while wg_i stays high does not alter the output sequence.
- R8: In any cycle with wg_i low, wr_valid_o and wr_bit_o are 0 combinationally. The next rise of the gate restarts the frame from its first bit.
- R9: squelch_o and agc_hold_o are 1 whenever wg_i is 1. agc_hold_o is 0 whenever wg_i is 0.
- R10: After wg_i falls, squelch_o stays 1 through the clock cycle in which wg_i is first low. It then stays 1 for a further 8·D pulses of ref_tick_i, where D is sq_dly_i captured at the fall, and then drops to 0.
- R11: When no ref_tick_i pulses arrive, the squelch extension holds and squelch_o stays 1. Once squelch_o has dropped with wg_i low, it stays 0 until wg_i rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wg_i | input | 1 | Write gate, active high |
| mode_i | input | 2 | Write mode: 00 normal, 01 PRBS test, 1x direct |
| pre_len_i | input | 8 | Preamble length in bytes |
| sync_byte_i | input | 8 | Sync byte, sent MSB first |
| enc_bit_i | input | 1 | Encoded user data bit |
| raw_bit_i | input | 1 | Raw bit for direct mode |
| sq_dly_i | input | 3 | Post-write squelch delay in units of 8 reference periods |
| ref_tick_i | input | 1 | One-cycle pulse per reference-clock period |
| wr_valid_o | output | 1 | Output bit is valid |
| wr_bit_o | output | 1 | Serial write bit toward precompensation |
| data_req_o | output | 1 | Encoder bit is being consumed this cycle |
| squelch_o | output | 1 | Read front-end squelch |
| agc_hold_o | output | 1 | Gain loop hold |

## Verification
The hardest state to reach is a squelch extension stalled by missing reference ticks. The sweep always ticks, so a dedicated sequence ends a short direct write with ref_tick_i held low. It then watches squelch_o stay high for many cycles and counts the exact number of high cycles left once ticks resume. A second hard case is a change of mode, preamble length and sync byte in the first cycle of a write. The sweep does this on one delay setting for every mode and length, and checks each output bit against the values captured at the rise. A gate dropped in the middle of the preamble, followed by a fresh write, checks that the frame restarts from its first bit.

// File: rtl/wgs_pkg.sv
package wgs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_SYNC = 3'd2,
      ST_PAY  = 3'd3,
      ST_DIR  = 3'd4
   } wgs_state_e;

   typedef enum logic [1:0] {
      MD_NORMAL     = 2'b00,
      MD_TEST       = 2'b01,
      MD_DIRECT     = 2'b10,
      MD_DIRECT_ALT = 2'b11
   } wgs_mode_e;

endpackage

// File: rtl/wgs_frame_fsm.sv
module wgs_frame_fsm
   import wgs_pkg::*;
#(
   parameter int PRE_W     = 8,
   parameter int SYNC_W    = 8,
   parameter bit PRE_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wg_i,
   input  logic [1:0]        mode_i,
   input  logic [PRE_W-1:0]  pre_len_i,
   input  logic [SYNC_W-1:0] sync_i,
   output wgs_state_e        state_o,
   output wgs_mode_e         mode_o,
   output logic              start_o,
   output logic              frame_bit_o
);

   localparam int SIDX_W = (SYNC_W > 1) ? $clog2(SYNC_W) : 1;
   localparam int CNT_W  = (PRE_W + 3 > SIDX_W) ? PRE_W + 3 : SIDX_W;

   if (PRE_W < 1) begin : g_bad_pre
      $error("wgs_frame_fsm: PRE_W must be at least 1");
   end
   if (SYNC_W < 2) begin : g_bad_sync
      $error("wgs_frame_fsm: SYNC_W must be at least 2");
   end

   wgs_state_e        state_q;
   wgs_mode_e         mode_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PRE_W-1:0]  plen_q;
   logic [SYNC_W-1:0] sync_sh_q;
   logic [CNT_W-1:0]  pre_bits;

   assign pre_bits = CNT_W'({plen_q, 3'b000});
   assign start_o  = (state_q == ST_IDLE) && wg_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         mode_q    <= MD_NORMAL;
         cnt_q     <= '0;
         plen_q    <= '0;
         sync_sh_q <= '0;
      end else if (!wg_i) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               mode_q    <= wgs_mode_e'(mode_i);
               plen_q    <= pre_len_i;
               sync_sh_q <= sync_i;
               cnt_q     <= '0;
               if (mode_i[1])
                  state_q <= ST_DIR;
               else if (pre_len_i == '0)
                  state_q <= ST_SYNC;
               else
                  state_q <= ST_PRE;
            end
            ST_PRE: begin
               if (cnt_q == pre_bits - CNT_W'(1)) begin
                  cnt_q   <= '0;
                  state_q <= ST_SYNC;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_SYNC: begin
               sync_sh_q <= sync_sh_q << 1;
               if (cnt_q == CNT_W'(SYNC_W - 1)) begin
                  cnt_q   <= '0;
                  state_q <= ST_PAY;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: state_q <= state_q;
         endcase
      end
   end

   always_comb begin
      frame_bit_o = 1'b0;
      if (state_q == ST_PRE)
         frame_bit_o = cnt_q[0] ^ PRE_FIRST;
      else if (state_q == ST_SYNC)
         frame_bit_o = sync_sh_q[SYNC_W-1];
   end

   assign state_o = state_q;
   assign mode_o  = mode_q;

endmodule

// File: rtl/wgs_prbs.sv
module wgs_prbs #(
   parameter int LEN = 7,
   parameter int TAP = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seed_i,
   input  logic step_i,
   output logic bit_o
);

   if (LEN < 3) begin : g_bad_len
      $error("wgs_prbs: LEN must be at least 3");
   end
   if (TAP < 1 || TAP >= LEN) begin : g_bad_tap
      $error("wgs_prbs: TAP must lie in 1..LEN-1");
   end

   logic [LEN-1:0] sr_q;
   logic           fb;

   assign fb = sr_q[LEN-1] ^ sr_q[TAP-1];

   always_ff @(posedge clk) begin
      if (!rst_n)
         sr_q <= '1;
      else if (seed_i)
         sr_q <= '1;
      else if (step_i)
         sr_q <= {sr_q[LEN-2:0], fb};
   end

   assign bit_o = sr_q[LEN-1];

endmodule

// File: rtl/wgs_squelch_ext.sv
module wgs_squelch_ext #(
   parameter int DLY_W     = 3,
   parameter int STEP_LOG2 = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wg_i,
   input  logic [DLY_W-1:0] dly_i,
   input  logic             tick_i,
   output logic             squelch_o
);

   localparam int CNT_W = DLY_W + STEP_LOG2;

   if (DLY_W < 1) begin : g_bad_dly
      $error("wgs_squelch_ext: DLY_W must be at least 1");
   end
   if (STEP_LOG2 < 0) begin : g_bad_step
      $error("wgs_squelch_ext: STEP_LOG2 must not be negative");
   end

   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt_q;
   logic             wg_q;

   if (STEP_LOG2 == 0) begin : g_unit_step
      assign load_val = dly_i;
   end else begin : g_scaled_step
      assign load_val = {dly_i, {STEP_LOG2{1'b0}}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wg_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         wg_q <= wg_i;
         if (wg_i)
            cnt_q <= '0;
         else if (wg_q)
            cnt_q <= load_val;
         else if (tick_i && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign squelch_o = wg_i | wg_q | (cnt_q != '0);

endmodule

// File: rtl/wg_path_seq.sv
module wg_path_seq
   import wgs_pkg::*;
#(
   parameter int PRE_W         = 8,
   parameter int SYNC_W        = 8,
   parameter int DLY_W         = 3,
   parameter int DLY_STEP_LOG2 = 3,
   parameter int PRBS_LEN      = 7,
   parameter int PRBS_TAP      = 6,
   parameter bit PRE_FIRST     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wg_i,
   input  logic [1:0]        mode_i,
   input  logic [PRE_W-1:0]  pre_len_i,
   input  logic [SYNC_W-1:0] sync_byte_i,
   input  logic              enc_bit_i,
   input  logic              raw_bit_i,
   input  logic [DLY_W-1:0]  sq_dly_i,
   input  logic              ref_tick_i,
   output logic              wr_valid_o,
   output logic              wr_bit_o,
   output logic              data_req_o,
   output logic              squelch_o,
   output logic              agc_hold_o
);

   wgs_state_e st;
   wgs_mode_e  mode_q;
   logic       start;
   logic       frame_bit;
   logic       prbs_bit;
   logic       prbs_step;
   logic       in_pay;

   wgs_frame_fsm #(
      .PRE_W     (PRE_W),
      .SYNC_W    (SYNC_W),
      .PRE_FIRST (PRE_FIRST)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wg_i        (wg_i),
      .mode_i      (mode_i),
      .pre_len_i   (pre_len_i),
      .sync_i      (sync_byte_i),
      .state_o     (st),
      .mode_o      (mode_q),
      .start_o     (start),
      .frame_bit_o (frame_bit)
   );

   assign in_pay    = wg_i && (st == ST_PAY);
   assign prbs_step = in_pay && (mode_q == MD_TEST);

   wgs_prbs #(
      .LEN (PRBS_LEN),
      .TAP (PRBS_TAP)
   ) u_prbs (
      .clk    (clk),
      .rst_n  (rst_n),
      .seed_i (start),
      .step_i (prbs_step),
      .bit_o  (prbs_bit)
   );

   wgs_squelch_ext #(
      .DLY_W     (DLY_W),
      .STEP_LOG2 (DLY_STEP_LOG2)
   ) u_sq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wg_i      (wg_i),
      .dly_i     (sq_dly_i),
      .tick_i    (ref_tick_i),
      .squelch_o (squelch_o)
   );

   always_comb begin
      wr_valid_o = wg_i && (st != ST_IDLE);
      wr_bit_o   = 1'b0;
      if (wr_valid_o) begin
         unique case (st)
            ST_PRE, ST_SYNC: wr_bit_o = frame_bit;
            ST_PAY:          wr_bit_o = (mode_q == MD_TEST) ? prbs_bit : enc_bit_i;
            ST_DIR:          wr_bit_o = raw_bit_i;
            default:         wr_bit_o = 1'b0;
         endcase
      end
   end

   assign data_req_o = in_pay && (mode_q == MD_NORMAL);
   assign agc_hold_o = wg_i;

endmodule

// File: rtl/wgs_checker.sv
module wgs_checker
   import wgs_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       wg_i,
   input logic       wr_valid_o,
   input logic       data_req_o,
   input logic       squelch_o,
   input logic       agc_hold_o,
   input wgs_state_e state_i,
   input wgs_mode_e  mode_i
);

   // R8: no output while the gate is low
   a_r8_quiet_without_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !wg_i |-> !wr_valid_o);

   // R9: read side protected during write
   a_r9_protect_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      wg_i |-> (squelch_o && agc_hold_o));

   // R10: squelch survives the fall of the gate
   a_r10_squelch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wg_i) |-> squelch_o);

   // R11: squelch does not come back without a new write
   a_r11_no_respawn: assert property (@(posedge clk) disable iff (!rst_n)
      (!wg_i && $past(!wg_i) && $past(!squelch_o)) |-> !squelch_o);

   // R4: payload request only after a header cycle with the gate high
   a_r4_req_after_header: assert property (@(posedge clk) disable iff (!rst_n)
      data_req_o |-> ($past(wg_i) && wr_valid_o));

   // R6: direct mode never requests encoder data
   a_r6_direct_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_DIR) |-> !data_req_o);

   // R7: captured mode is stable for the whole write
   a_r7_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i != ST_IDLE && $past(state_i) != ST_IDLE) |-> $stable(mode_i));

endmodule

bind wg_path_seq wgs_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wg_i       (wg_i),
   .wr_valid_o (wr_valid_o),
   .data_req_o (data_req_o),
   .squelch_o  (squelch_o),
   .agc_hold_o (agc_hold_o),
   .state_i    (st),
   .mode_i     (mode_q)
);

// File: tb/wg_path_seq_tb.sv
module wg_path_seq_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wg_i;
   logic [1:0] mode_i;
   logic [7:0] pre_len_i;
   logic [7:0] sync_byte_i;
   logic       enc_bit_i;
   logic       raw_bit_i;
   logic [2:0] sq_dly_i;
   logic       ref_tick_i;
   logic       wr_valid_o;
   logic       wr_bit_o;
   logic       data_req_o;
   logic       squelch_o;
   logic       agc_hold_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wg_path_seq dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wg_i        (wg_i),
      .mode_i      (mode_i),
      .pre_len_i   (pre_len_i),
      .sync_byte_i (sync_byte_i),
      .enc_bit_i   (enc_bit_i),
      .raw_bit_i   (raw_bit_i),
      .sq_dly_i    (sq_dly_i),
      .ref_tick_i  (ref_tick_i),
      .wr_valid_o  (wr_valid_o),
      .wr_bit_o    (wr_bit_o),
      .data_req_o  (data_req_o),
      .squelch_o   (squelch_o),
      .agc_hold_o  (agc_hold_o)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic pat(input int k, input int salt);
      return ((k * salt + salt / 2) % 7) > 2;
   endfunction

   // one write followed by the squelch tail; expected values from R2..R10
   task automatic do_write(input logic [1:0] md, input int plen, input logic [7:0] sb,
                           input int npay, input int dly, input bit flip);
      int         hdr;
      int         total;
      logic [6:0] m;
      logic       eb;
      logic       er;
      string      tag;
      hdr   = md[1] ? 0 : plen * 8 + 8;
      total = hdr + npay;
      m     = 7'h7f;
      @(negedge clk);
      mode_i      = md;
      pre_len_i   = 8'(plen);
      sync_byte_i = sb;
      sq_dly_i    = 3'(dly);
      ref_tick_i  = 1'b1;
      wg_i        = 1'b1;
      enc_bit_i   = pat(0, 3);
      raw_bit_i   = pat(0, 5);
      for (int k = 0; k < total; k++) begin
         @(negedge clk);
         er = 1'b0;
         if (md[1]) begin
            eb = raw_bit_i; tag = "R6 direct";
         end else if (k < plen * 8) begin
            eb = 1'(k % 2); tag = "R2 preamble";
         end else if (k < hdr) begin
            eb = sb[7 - (k - plen * 8)]; tag = "R3 sync";
         end else if (md == 2'b00) begin
            eb = enc_bit_i; er = 1'b1; tag = "R4 normal";
         end else begin
            eb = m[6]; m = {m[5:0], m[6] ^ m[5]}; tag = "R5 prbs";
         end
         if (flip && k > 0) tag = {tag, " R7 held"};
         chk({tag, " bit"}, wr_bit_o, eb);
         chk({tag, " valid R2"}, wr_valid_o, 1'b1);
         chk({tag, " req R4"}, data_req_o, er);
         chk("R9 squelch in write", squelch_o, 1'b1);
         chk("R9 agc in write", agc_hold_o, 1'b1);
         if (flip && k == 0) begin
            mode_i      = ~md;
            pre_len_i   = pre_len_i + 8'd3;
            sync_byte_i = ~sb;
         end
         enc_bit_i = pat(k + 1, 3);
         raw_bit_i = pat(k + 1, 5);
      end
      wg_i = 1'b0;
      #1;
      chk("R8 valid drops", wr_valid_o, 1'b0);
      chk("R8 bit drops", wr_bit_o, 1'b0);
      chk("R10 squelch at fall", squelch_o, 1'b1);
      chk("R9 agc released", agc_hold_o, 1'b0);
      for (int j = 1; j <= dly * 8 + 3; j++) begin
         @(negedge clk);
         chk("R10 squelch tail", squelch_o, 1'(j <= dly * 8));
         chk("R9 agc low", agc_hold_o, 1'b0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int plens[4];
      plens = '{0, 1, 2, 5};
      rst_n = 1'b0; wg_i = 1'b0; mode_i = 2'b00; pre_len_i = 8'd0;
      sync_byte_i = 8'h00; enc_bit_i = 1'b0; raw_bit_i = 1'b0;
      sq_dly_i = 3'd0; ref_tick_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 reset valid", wr_valid_o, 1'b0);
      chk("R1 reset squelch", squelch_o, 1'b0);
      chk("R1 reset agc", agc_hold_o, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle valid", wr_valid_o, 1'b0);
      chk("R1 idle bit", wr_bit_o, 1'b0);
      chk("R1 idle req", data_req_o, 1'b0);
      chk("R1 idle squelch", squelch_o, 1'b0);

      // sweep mode x preamble length x squelch delay
      for (int md = 0; md < 4; md++)
         for (int pi = 0; pi < 4; pi++)
            for (int d = 0; d < 8; d++)
               do_write(2'(md), plens[pi], 8'(8'hB1 + md * 37 + d * 11), 20, d, d == 3);

      // R8: abort in the preamble, then a fresh write restarts the frame
      @(negedge clk);
      mode_i = 2'b00; pre_len_i = 8'd2; sync_byte_i = 8'hC3; sq_dly_i = 3'd1; wg_i = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R8 pre-abort preamble", wr_bit_o, 1'(k % 2));
      end
      wg_i = 1'b0;
      #1;
      chk("R8 abort valid", wr_valid_o, 1'b0);
      do_write(2'b00, 2, 8'h96, 12, 2, 1'b0);
      do_write(2'b01, 1, 8'h3C, 30, 0, 1'b0);

      // R11: squelch tail stalls without reference ticks
      @(negedge clk);
      mode_i = 2'b10; sq_dly_i = 3'd1; wg_i = 1'b1;
      repeat (3) @(negedge clk);
      wg_i = 1'b0; ref_tick_i = 1'b0;
      for (int j = 0; j < 20; j++) begin
         @(negedge clk);
         chk("R11 squelch stalled", squelch_o, 1'b1);
      end
      ref_tick_i = 1'b1;
      for (int j = 0; j < 10; j++) begin
         @(negedge clk);
         chk("R11 squelch resumes", squelch_o, 1'(j < 7));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule